// File: doc/BRIEF.md
# Double-Data-Rate Prefetch Data Path (two byte lanes)

This block sits between a memory core that moves one 32-bit word per clock and a 16-bit pin interface that moves one 16-bit beat on each half of the clock. It is split into two byte lanes. Each lane has its own data strobe and its own data-mask bit, so the two bytes are timed independently at the pins.

On the write side, the controller drives each strobe with its edges centred in the data eye. Each lane captures its byte and mask on the rising strobe edge and again on the falling strobe edge. Once both lanes have finished a rising/falling pair, the block hands the core one 32-bit word with a 4-bit byte-suppress mask and a one-cycle valid flag.

On the read side, the core offers one 32-bit word per clock with a valid flag. The block sends the word out as two beats on the following clock. During the high phase it drives the lower half and both strobes high. During the low phase it drives the upper half and both strobes low, so the strobe edges line up with the data transitions. A burst of length L is presented as L/2 consecutive valid words. Between bursts the data and strobe output enables are off. Delay lines and phase calibration are treated as ideal.

Top module: `ddr_prefetch_dp`

## Requirements
- R1: While `rst` is high and at the first sample after it, `wr_valid`, `dq_oe` and `dqs_oe` are all 0.
- R2: A write pair places the byte captured on a lane's rising strobe edge in the lower 16 bits of `wr_word` and the byte from the falling edge in the upper 16 bits. `wr_valid` is high for exactly the one clock cycle that follows the first core rising edge at which both lanes have completed their pair.
- R3: Lane 0 captures `dq_i[7:0]` and `dm_i[0]` on `dqs_i[0]`. Lane 1 captures `dq_i[15:8]` and `dm_i[1]` on `dqs_i[1]`. If one lane's falling edge arrives after a core edge, `wr_valid` is held off until the core edge that follows that lane's completion.
- R4: The mask bits are sampled with every beat. `wr_mask[b]` = 1 means byte b of `wr_word` must not be written. The bit order is: bit0 = first beat lane 0, bit1 = first beat lane 1, bit2 = second beat lane 0, bit3 = second beat lane 1.
- R5: A word presented with `rd_valid` at core edge k appears on the pins in the cycle after edge k: `rd_word[15:0]` while `clk` is high and `rd_word[31:16]` while `clk` is low.
- R6: During a read beat, both bits of `dqs_o` are 1 in the high phase and 0 in the low phase, so strobe edges coincide with data transitions.
- R7: In a cycle that follows an edge without `rd_valid`, `dq_oe` = 0, `dqs_oe` = 2'b00, `dq_o` = 0 and `dqs_o` = 2'b00. `dq_oe` rises only in the cycle after an edge where `rd_valid` was high.
- R8: Words offered on consecutive core edges (read side) produce gap-free consecutive beat pairs with the output enables held high. Pairs completed in consecutive cycles (write side) produce `wr_valid` on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; both phases carry read beats |
| rst | input | 1 | Synchronous active-high reset |
| dq_i | input | 16 | Write data at the pins |
| dm_i | input | 2 | Per-lane write byte-suppress at the pins |
| dqs_i | input | 2 | Per-lane write strobe from the controller |
| wr_word | output | 32 | Assembled write word to the core |
| wr_mask | output | 4 | Per-byte suppress mask for `wr_word` |
| wr_valid | output | 1 | One-cycle flag that `wr_word`/`wr_mask` are new |
| rd_word | input | 32 | Read word from the core |
| rd_valid | input | 1 | `rd_word` is to be sent out |
| dq_o | output | 16 | Read data at the pins |
| dq_oe | output | 1 | Output enable for `dq_o` |
| dqs_o | output | 2 | Per-lane read strobe |
| dqs_oe | output | 2 | Per-lane output enable for `dqs_o` |

## Verification
The hardest case to reach from the ports is lane skew on writes: one lane's pair finishes before a core edge and the other lane's finishes after it. Only then does the completion gate matter, and it must hold the word back for a cycle. The bench delays lane 1's whole strobe/data timeline by several nanoseconds so that its falling edge lands just past a core edge. It then checks that `wr_valid` stays low at that edge and rises one cycle later with all four bytes intact. Back-to-back traffic in both directions is driven with concurrent stimulus and checking threads, so that no idle cycle hides a dropped word.

// File: rtl/ddr_dp_pkg.sv
`timescale 1ns/1ps
package ddr_dp_pkg;
    localparam int LANES   = 2;
    localparam int LANE_W  = 8;
    localparam int PIN_W   = LANES * LANE_W;
    localparam int CORE_W  = 2 * PIN_W;
    localparam int MASK_W  = 2 * LANES;

    typedef struct packed {
        logic [LANE_W-1:0] data;
        logic              mask;
    } beat_t;

    typedef struct packed {
        logic [CORE_W-1:0] word;
        logic [MASK_W-1:0] mask;
    } core_wr_t;

    // first beat forms the low half, second beat the high half
    function automatic core_wr_t assemble(input beat_t [LANES-1:0] first,
                                          input beat_t [LANES-1:0] second);
        core_wr_t r;
        for (int l = 0; l < LANES; l++) begin
            r.word[l*LANE_W +: LANE_W]         = first[l].data;
            r.word[PIN_W + l*LANE_W +: LANE_W] = second[l].data;
            r.mask[l]                          = first[l].mask;
            r.mask[LANES + l]                  = second[l].mask;
        end
        return r;
    endfunction
endpackage

// File: rtl/ddr_wr_lane.sv
`timescale 1ns/1ps
module ddr_wr_lane
    import ddr_dp_pkg::*;
(
    input  logic              strobe,
    input  logic [LANE_W-1:0] pin_data,
    input  logic              pin_mask,
    output beat_t             beat_rise,
    output beat_t             beat_fall,
    output logic              pair_tog
);
    beat_t rise_q;
    beat_t fall_q;
    logic  tog_q = 1'b0;

    always_ff @(posedge strobe) begin
        rise_q <= '{data: pin_data, mask: pin_mask};
    end

    always_ff @(negedge strobe) begin
        fall_q <= '{data: pin_data, mask: pin_mask};
        tog_q  <= ~tog_q;
    end

    assign beat_rise = rise_q;
    assign beat_fall = fall_q;
    assign pair_tog  = tog_q;
endmodule

// File: rtl/ddr_wr_gather.sv
`timescale 1ns/1ps
module ddr_wr_gather
    import ddr_dp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANES-1:0]      lane_tog,
    input  beat_t [LANES-1:0]     lane_rise,
    input  beat_t [LANES-1:0]     lane_fall,
    output logic [CORE_W-1:0]     wr_word,
    output logic [MASK_W-1:0]     wr_mask,
    output logic                  wr_valid
);
    logic [LANES-1:0] seen_q;
    logic             all_done;
    core_wr_t         out_q;
    logic             valid_q;

    assign all_done = &(lane_tog ^ seen_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= lane_tog;
            valid_q <= 1'b0;
            out_q   <= '0;
        end else begin
            valid_q <= all_done;
            if (all_done) begin
                seen_q <= lane_tog;
                out_q  <= assemble(lane_rise, lane_fall);
            end
        end
    end

    assign wr_word  = out_q.word;
    assign wr_mask  = out_q.mask;
    assign wr_valid = valid_q;
endmodule

// File: rtl/ddr_rd_ser.sv
`timescale 1ns/1ps
module ddr_rd_ser
    import ddr_dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CORE_W-1:0] rd_word,
    input  logic              rd_valid,
    output logic [PIN_W-1:0]  dq_o,
    output logic              dq_oe,
    output logic [LANES-1:0]  dqs_o,
    output logic [LANES-1:0]  dqs_oe
);
    logic             active_q;
    logic [PIN_W-1:0] lo_q;
    logic [PIN_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else begin
            active_q <= rd_valid;
            if (rd_valid) begin
                lo_q <= rd_word[PIN_W-1:0];
                hi_q <= rd_word[CORE_W-1:PIN_W];
            end
        end
    end

    assign dq_o  = active_q ? (clk ? lo_q : hi_q) : '0;
    assign dq_oe = active_q;

    for (genvar l = 0; l < LANES; l++) begin : g_strobe
        assign dqs_o[l]  = active_q & clk;
        assign dqs_oe[l] = active_q;
    end
endmodule

// File: rtl/ddr_prefetch_dp.sv
`timescale 1ns/1ps
module ddr_prefetch_dp
    import ddr_dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PIN_W-1:0]  dq_i,
    input  logic [LANES-1:0]  dm_i,
    input  logic [LANES-1:0]  dqs_i,
    output logic [CORE_W-1:0] wr_word,
    output logic [MASK_W-1:0] wr_mask,
    output logic              wr_valid,
    input  logic [CORE_W-1:0] rd_word,
    input  logic              rd_valid,
    output logic [PIN_W-1:0]  dq_o,
    output logic              dq_oe,
    output logic [LANES-1:0]  dqs_o,
    output logic [LANES-1:0]  dqs_oe
);
    beat_t [LANES-1:0] rise_b;
    beat_t [LANES-1:0] fall_b;
    logic  [LANES-1:0] tog;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ddr_wr_lane i_lane (
            .strobe    (dqs_i[l]),
            .pin_data  (dq_i[l*LANE_W +: LANE_W]),
            .pin_mask  (dm_i[l]),
            .beat_rise (rise_b[l]),
            .beat_fall (fall_b[l]),
            .pair_tog  (tog[l])
        );
    end

    ddr_wr_gather i_gather (
        .clk       (clk),
        .rst       (rst),
        .lane_tog  (tog),
        .lane_rise (rise_b),
        .lane_fall (fall_b),
        .wr_word   (wr_word),
        .wr_mask   (wr_mask),
        .wr_valid  (wr_valid)
    );

    ddr_rd_ser i_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_word  (rd_word),
        .rd_valid (rd_valid),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe),
        .dqs_o    (dqs_o),
        .dqs_oe   (dqs_oe)
    );
endmodule

// File: rtl/ddr_prefetch_dp_chk.sv
`timescale 1ns/1ps
module ddr_prefetch_dp_chk
    import ddr_dp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rd_valid,
    input logic             dq_oe,
    input logic [LANES-1:0] dqs_oe,
    input logic             wr_valid
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!wr_valid && !dq_oe && dqs_oe == '0));

    // R5
    read_enable_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> dq_oe);

    // R7
    idle_tristate_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> (!dq_oe && dqs_oe == '0));

    // R7
    oe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> $past(rd_valid));
endmodule

bind ddr_prefetch_dp ddr_prefetch_dp_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_valid (rd_valid),
    .dq_oe    (dq_oe),
    .dqs_oe   (dqs_oe),
    .wr_valid (wr_valid)
);

// File: tb/test_ddr_prefetch_dp.sv
`timescale 1ns/1ps
module test_ddr_prefetch_dp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] dq_i = '0;
    logic [1:0]  dm_i = '0;
    logic [1:0]  dqs_i = '0;
    logic [31:0] wr_word;
    logic [3:0]  wr_mask;
    logic        wr_valid;
    logic [31:0] rd_word = '0;
    logic        rd_valid = 1'b0;
    logic [15:0] dq_o;
    logic        dq_oe;
    logic [1:0]  dqs_o;
    logic [1:0]  dqs_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ddr_prefetch_dp i_ddr_prefetch_dp (
        .clk(clk), .rst(rst), .dq_i(dq_i), .dm_i(dm_i), .dqs_i(dqs_i),
        .wr_word(wr_word), .wr_mask(wr_mask), .wr_valid(wr_valid),
        .rd_word(rd_word), .rd_valid(rd_valid), .dq_o(dq_o), .dq_oe(dq_oe),
        .dqs_o(dqs_o), .dqs_oe(dqs_oe)
    );

    // entry: {first beat[15:0], second beat[15:0], first mask[1:0], second mask[1:0]}
    localparam int NV = 6;
    localparam logic [35:0] VEC [NV] = '{
        {16'h1234, 16'h5678, 2'b00, 2'b00},
        {16'hA5C3, 16'h3CA5, 2'b01, 2'b10},
        {16'hFFFF, 16'h0000, 2'b11, 2'b00},
        {16'h0000, 16'hFFFF, 2'b00, 2'b11},
        {16'h8001, 16'h7FFE, 2'b10, 2'b01},
        {16'hDEAD, 16'hBEEF, 2'b11, 2'b11}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // call just after a core rising edge; pair completes before the next edge
    task automatic wr_pair(input logic [15:0] b0, input logic [15:0] b1,
                           input logic [1:0] m0, input logic [1:0] m1);
        #1 dq_i = b0; dm_i = m0;
        #2 dqs_i = 2'b11;
        #2 dq_i = b1; dm_i = m1;
        #2 dqs_i = 2'b00;
    endtask

    task automatic rd_one(input logic [31:0] w, input string tag);
        #1 rd_valid = 1'b1; rd_word = w;
        @(posedge clk); #1 rd_valid = 1'b0;
        #1;
        check({tag, " R5 low half"}, {16'h0, dq_o}, {16'h0, w[15:0]});
        check({tag, " R6 strobe high"}, {30'h0, dqs_o}, 32'h3);
        check({tag, " R7 oe on"}, {29'h0, dq_oe, dqs_oe}, 32'h7);
        #5;
        check({tag, " R5 high half"}, {16'h0, dq_o}, {16'h0, w[31:16]});
        check({tag, " R6 strobe low"}, {30'h0, dqs_o}, 32'h0);
        @(posedge clk); #2;
        check({tag, " R7 idle"}, {13'h0, dq_oe, dqs_oe, dqs_o, dq_o}, 32'h0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset quiet", {30'h0, wr_valid, dq_oe}, 32'h0);
        check("R1 reset strobe oe", {30'h0, dqs_oe}, 32'h0);
        @(posedge clk); #1 rst = 1'b0;
        @(posedge clk); #2;
        check("R1 after reset", {29'h0, wr_valid, dq_oe, |dqs_oe}, 32'h0);

        // table walk: write pair then read back the assembled word
        for (int i = 0; i < NV; i++) begin
            logic [31:0] ew;
            logic [3:0]  em;
            ew = {VEC[i][19:4], VEC[i][35:20]};
            em = {VEC[i][1:0], VEC[i][3:2]};
            @(posedge clk);
            wr_pair(VEC[i][35:20], VEC[i][19:4], VEC[i][3:2], VEC[i][1:0]);
            @(posedge clk); #2;
            check("R2 valid", {31'h0, wr_valid}, 32'h1);
            check("R2 word order", wr_word, ew);
            check("R4 mask order", {28'h0, wr_mask}, {28'h0, em});
            @(posedge clk); #2;
            check("R2 single pulse", {31'h0, wr_valid}, 32'h0);
            rd_one(ew, "table");
        end

        // R3: lane 1 timeline lags by 6 ns so its falling edge misses a core edge
        @(posedge clk);
        fork
            begin
                #1 dq_i[7:0] = 8'h11; dm_i[0] = 1'b1;
                #2 dqs_i[0] = 1'b1;
                #2 dq_i[7:0] = 8'h33; dm_i[0] = 1'b0;
                #2 dqs_i[0] = 1'b0;
            end
            begin
                #7 dq_i[15:8] = 8'h22; dm_i[1] = 1'b0;
                #2 dqs_i[1] = 1'b1;
                #2 dq_i[15:8] = 8'h44; dm_i[1] = 1'b1;
                #2 dqs_i[1] = 1'b0;
            end
            begin
                @(posedge clk); #2;
                check("R3 held for lagging lane", {31'h0, wr_valid}, 32'h0);
                @(posedge clk); #2;
                check("R3 valid after lane 1", {31'h0, wr_valid}, 32'h1);
                check("R3 skewed word", wr_word, 32'h44332211);
                check("R4 skewed mask", {28'h0, wr_mask}, 32'h9);
            end
        join
        @(posedge clk); #2;
        check("R3 single pulse", {31'h0, wr_valid}, 32'h0);

        // R8 write: consecutive pairs
        @(posedge clk);
        fork
            begin
                wr_pair(16'hCAFE, 16'hF00D, 2'b01, 2'b00);
                @(posedge clk);
                wr_pair(16'h0102, 16'h0304, 2'b00, 2'b10);
            end
            begin
                @(posedge clk); #2;
                check("R8 write first", wr_word, 32'hF00DCAFE);
                check("R8 write first valid", {31'h0, wr_valid}, 32'h1);
                @(posedge clk); #2;
                check("R8 write second", wr_word, 32'h03040102);
                check("R8 write second valid", {31'h0, wr_valid}, 32'h1);
                check("R8 write second mask", {28'h0, wr_mask}, 32'h8);
            end
        join

        // R8 read: consecutive words keep enables high
        @(posedge clk);
        #1 rd_valid = 1'b1; rd_word = 32'h89ABCDEF;
        @(posedge clk); #1 rd_word = 32'h01234567;
        #1;
        check("R8 read w0 low", {16'h0, dq_o}, 32'h0000CDEF);
        #5;
        check("R8 read w0 high", {16'h0, dq_o}, 32'h000089AB);
        @(posedge clk); #1 rd_valid = 1'b0;
        #1;
        check("R8 read w1 low", {16'h0, dq_o}, 32'h00004567);
        check("R8 oe held", {29'h0, dq_oe, dqs_oe}, 32'h7);
        #5;
        check("R8 read w1 high", {16'h0, dq_o}, 32'h00000123);
        check("R6 strobe low w1", {30'h0, dqs_o}, 32'h0);
        @(posedge clk); #2;
        check("R7 idle after burst", {13'h0, dq_oe, dqs_oe, dqs_o, dq_o}, 32'h0);

        // R1: reset in the middle of a read
        #1 rd_valid = 1'b1; rd_word = 32'h55AA55AA; rst = 1'b1;
        @(posedge clk); #2;
        check("R1 reset overrides read", {29'h0, dq_oe, dqs_oe}, 32'h0);
        rd_valid = 1'b0; rst = 1'b0;
        @(posedge clk); #2;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule